// File: doc/BRIEF.md
# Nested interrupt priority arbiter

This block selects, every clock cycle, which of a set of configurable interrupt lines should be served next, and says whether that line may cut into the handler that is running now. Each line has an 8-bit priority. A smaller number means a more urgent line. Only the upper `IMPL_BITS` bits of each priority are kept. A 3-bit grouping value divides the kept priority into two parts. The upper part is the preemption level, which decides whether one handler may interrupt another. The lower part is the sub-priority, which only orders lines that sit on the same preemption level.

The block holds a pending bit and an active bit for each line. It also keeps a small stack that records the priorities of the handlers now nested. An acknowledge input accepts the line on offer. An end-of-handler input retires the innermost handler and brings back the level of the handler beneath it. Two masks narrow which configurable lines can win. The first is a global mask bit. The second is a base-priority threshold. A non-maskable input and a fault input skip both masks and always request preemption.

Top module: `irq_prio_arb`

## Requirements
- R1: Among the eligible lines, the winner is the one whose kept priority is numerically smallest. On a tie, the lowest line index wins. `win_prio_o` reports the kept priority of the winner.
- R2: A line's kept priority is its priority with the low `8-IMPL_BITS` bits cleared (with the default of 4, `prio & 8'hF0`). The base-priority value is cut down the same way. Lines that differ only in the cleared bits are treated as equal.
- R3: For a grouping value g (0..7), the preemption level is the kept priority with bits [g:0] cleared. `preempt_o` from a configurable winner is high when three conditions hold: a winner exists, the stack is not full, and either no handler is active or the winner's level is strictly smaller than the innermost active level.
- R4: While `nmi_i` is high, `preempt_o` and `sys_nmi_o` are 1 and `sys_fault_o` is 0, whatever the masks are.
- R5: While `fault_i` is high and `nmi_i` is low, `preempt_o` and `sys_fault_o` are 1, whatever the masks are.
- R6: While `gmask_i` is high, no configurable line can win (`win_valid_o` = 0).
- R7: If the kept base-priority value is nonzero, a line can win only when its kept priority is strictly below that value. A kept value of 0 switches this check off.
- R8: A rising edge on `req_i[i]` sets `pend_o[i]` in the next cycle. Register writes take precedence in this order: `clr_pend_i[i]` first (clears), then `set_pend_i[i]` (sets), then a clear caused by acknowledge, and last the request edge.
- R9: An acknowledge takes effect only when `ack_i` is high, a configurable winner is requesting preemption, and `eoi_i`, `nmi_i` and `fault_i` are all low. When it takes effect, in the next cycle the winner's pending bit is clear, its active bit is set, and `active_prio_o` equals its kept priority.
- R10: When `eoi_i` is high and a handler is active, the innermost handler is removed. Its active bit clears and `active_prio_o` returns to the level beneath it, or to 8'hFF when none is left. When nothing is active, `eoi_i` does nothing.
- R11: A line whose active bit is set cannot win, even if it is pending again.
- R12: When `STACK_DEPTH` handlers are active, a configurable winner does not request preemption, and `ack_i` is ignored.
- R13: A line whose enable bit is 0 keeps its pending state but cannot win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_LINES | Request lines, sampled for rising edges |
| en_i | input | N_LINES | Per-line enable |
| prio_i | input | N_LINES*8 | Priorities; line i uses bits [8i+7:8i] |
| group_i | input | 3 | Grouping value g |
| gmask_i | input | 1 | Global mask for configurable lines |
| basepri_i | input | 8 | Base-priority threshold, 0 = off |
| nmi_i | input | 1 | Non-maskable request |
| fault_i | input | 1 | Fault request |
| ack_i | input | 1 | Accept the line on offer |
| eoi_i | input | 1 | End of the innermost handler |
| set_pend_i | input | N_LINES | Force pending bits to 1 |
| clr_pend_i | input | N_LINES | Force pending bits to 0 |
| win_valid_o | output | 1 | A configurable line is eligible |
| win_idx_o | output | $clog2(N_LINES) | Index of the winning line |
| win_prio_o | output | 8 | Kept priority of the winning line |
| preempt_o | output | 1 | The offered source may interrupt now |
| sys_nmi_o | output | 1 | The non-maskable source is offered |
| sys_fault_o | output | 1 | The fault source is offered |
| pend_o | output | N_LINES | Pending bits |
| act_o | output | N_LINES | Active bits |
| active_prio_o | output | 8 | Innermost active kept priority, 8'hFF when idle |

## Verification
The properties make no assumption about when requests, masks or priorities change. Every input may change on any cycle, and the stimulus does change all of them, including priorities of lines that are already active. The properties do rely on one thing: a push onto the nesting stack happens only through an accepted acknowledge. Because of this, the number of active bits always equals the stack depth. The stimulus therefore toggles `ack_i` and `eoi_i` freely, in the same cycle as well, and counts on the block to drop any acknowledge it is not allowed to take.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 8;
  localparam int GRP_W  = $clog2(PRIO_W);

  typedef logic [PRIO_W-1:0] prio_t;

  // Mask that keeps only the upper ib bits of a priority value.
  function automatic prio_t kept_mask(int unsigned ib);
    prio_t m;
    for (int b = 0; b < PRIO_W; b++) m[b] = (b >= PRIO_W - int'(ib));
    return m;
  endfunction

  // Preemption level: the priority with bits [g:0] removed.
  function automatic prio_t level_of(prio_t p, logic [GRP_W-1:0] g);
    prio_t m;
    for (int b = 0; b < PRIO_W; b++) m[b] = (b > int'(g));
    return p & m;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_LINES = 16,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] set_i,
  input  logic [N_LINES-1:0] clr_i,
  input  logic               ack_fire_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] req_q;
  logic [N_LINES-1:0] req_rise;

  assign req_rise = req_i & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic ack_hit;
    assign ack_hit = ack_fire_i && (ack_idx_i == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend_o[i] <= 1'b0;
      else if (clr_i[i])    pend_o[i] <= 1'b0;
      else if (set_i[i])    pend_o[i] <= 1'b1;
      else if (ack_hit)     pend_o[i] <= 1'b0;
      else if (req_rise[i]) pend_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_win_sel.sv
module irq_win_sel
  import irq_arb_pkg::*;
#(
  parameter int N_LINES   = 16,
  parameter int IMPL_BITS = 4,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]        pend_i,
  input  logic [N_LINES-1:0]        en_i,
  input  logic [N_LINES-1:0]        act_i,
  input  logic [N_LINES*PRIO_W-1:0] prio_i,
  input  logic                      gmask_i,
  input  prio_t                     bp_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o,
  output prio_t                     prio_o
);
  localparam prio_t KMASK = kept_mask(IMPL_BITS);

  logic [N_LINES-1:0] elig;

  for (genvar i = 0; i < N_LINES; i++) begin : g_elig
    prio_t p;
    assign p = prio_i[i*PRIO_W +: PRIO_W] & KMASK;
    assign elig[i] = pend_i[i] && en_i[i] && !act_i[i] && !gmask_i &&
                     ((bp_i == '0) || (p < bp_i));
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < N_LINES; i++) begin
      prio_t p;
      p = prio_i[i*PRIO_W +: PRIO_W] & KMASK;
      if (elig[i] && (!valid_o || p < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = p;
      end
    end
  end
endmodule

// File: rtl/irq_act_stack.sv
module irq_act_stack
  import irq_arb_pkg::*;
#(
  parameter int N_LINES     = 16,
  parameter int STACK_DEPTH = 4,
  localparam int IDX_W = $clog2(N_LINES),
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1,
  localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [IDX_W-1:0]   push_idx_i,
  input  prio_t              push_prio_i,
  output logic [N_LINES-1:0] act_o,
  output prio_t              top_prio_o,
  output logic [CNT_W-1:0]   depth_o,
  output logic               empty_o,
  output logic               full_o
);
  prio_t            s_prio [STACK_DEPTH];
  logic [IDX_W-1:0] s_idx  [STACK_DEPTH];
  logic [PTR_W-1:0] top_ptr;
  logic [PTR_W-1:0] new_ptr;

  assign empty_o    = (depth_o == '0);
  assign full_o     = (depth_o == CNT_W'(STACK_DEPTH));
  assign top_ptr    = PTR_W'(depth_o - 1'b1);
  assign new_ptr    = PTR_W'(depth_o);
  assign top_prio_o = s_prio[top_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_o <= '0;
      act_o   <= '0;
    end else if (pop_i && !empty_o) begin
      depth_o               <= depth_o - 1'b1;
      act_o[s_idx[top_ptr]] <= 1'b0;
    end else if (push_i && !full_o) begin
      depth_o           <= depth_o + 1'b1;
      act_o[push_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !pop_i && !full_o) begin
      s_prio[new_ptr] <= push_prio_i;
      s_idx[new_ptr]  <= push_idx_i;
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int N_LINES     = 16,
  parameter int IMPL_BITS   = 4,
  parameter int STACK_DEPTH = 4,
  localparam int IDX_W = $clog2(N_LINES),
  localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        req_i,
  input  logic [N_LINES-1:0]        en_i,
  input  logic [N_LINES*PRIO_W-1:0] prio_i,
  input  logic [GRP_W-1:0]          group_i,
  input  logic                      gmask_i,
  input  logic [PRIO_W-1:0]         basepri_i,
  input  logic                      nmi_i,
  input  logic                      fault_i,
  input  logic                      ack_i,
  input  logic                      eoi_i,
  input  logic [N_LINES-1:0]        set_pend_i,
  input  logic [N_LINES-1:0]        clr_pend_i,
  output logic                      win_valid_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [PRIO_W-1:0]         win_prio_o,
  output logic                      preempt_o,
  output logic                      sys_nmi_o,
  output logic                      sys_fault_o,
  output logic [N_LINES-1:0]        pend_o,
  output logic [N_LINES-1:0]        act_o,
  output logic [PRIO_W-1:0]         active_prio_o
);
  localparam prio_t KMASK = kept_mask(IMPL_BITS);

  // Named internal events, also observed by the bound checker.
  prio_t            bp_w;
  prio_t            top_prio_w;
  logic [CNT_W-1:0] depth_w;
  logic             empty_w;
  logic             full_w;
  logic             cfg_pre_w;
  logic             sys_busy_w;
  logic             ack_fire_w;
  logic             pop_w;

  assign bp_w = basepri_i & KMASK;

  irq_pend_bank #(.N_LINES(N_LINES)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .set_i      (set_pend_i),
    .clr_i      (clr_pend_i),
    .ack_fire_i (ack_fire_w),
    .ack_idx_i  (win_idx_o),
    .pend_o     (pend_o)
  );

  irq_win_sel #(.N_LINES(N_LINES), .IMPL_BITS(IMPL_BITS)) u_sel (
    .pend_i  (pend_o),
    .en_i    (en_i),
    .act_i   (act_o),
    .prio_i  (prio_i),
    .gmask_i (gmask_i),
    .bp_i    (bp_w),
    .valid_o (win_valid_o),
    .idx_o   (win_idx_o),
    .prio_o  (win_prio_o)
  );

  irq_act_stack #(.N_LINES(N_LINES), .STACK_DEPTH(STACK_DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (ack_fire_w),
    .pop_i       (pop_w),
    .push_idx_i  (win_idx_o),
    .push_prio_i (win_prio_o),
    .act_o       (act_o),
    .top_prio_o  (top_prio_w),
    .depth_o     (depth_w),
    .empty_o     (empty_w),
    .full_o      (full_w)
  );

  assign cfg_pre_w = win_valid_o && !full_w &&
                     (empty_w || (level_of(win_prio_o, group_i) <
                                  level_of(top_prio_w, group_i)));
  assign sys_busy_w = nmi_i || fault_i;
  assign ack_fire_w = ack_i && !eoi_i && !sys_busy_w && cfg_pre_w;
  assign pop_w      = eoi_i && !empty_w;

  assign sys_nmi_o     = nmi_i;
  assign sys_fault_o   = fault_i && !nmi_i;
  assign preempt_o     = sys_busy_w || cfg_pre_w;
  assign active_prio_o = empty_w ? '1 : top_prio_w;
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int N_LINES     = 16,
  parameter int STACK_DEPTH = 4,
  localparam int IDX_W = $clog2(N_LINES),
  localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               nmi_i,
  input logic               fault_i,
  input logic               gmask_i,
  input logic               eoi_i,
  input logic [N_LINES-1:0] set_pend_i,
  input logic               win_valid_o,
  input logic [IDX_W-1:0]   win_idx_o,
  input logic [PRIO_W-1:0]  win_prio_o,
  input logic               preempt_o,
  input logic               sys_nmi_o,
  input logic               sys_fault_o,
  input logic [N_LINES-1:0] pend_o,
  input logic [N_LINES-1:0] act_o,
  input logic [PRIO_W-1:0]  active_prio_o,
  input prio_t              bp_w,
  input logic [CNT_W-1:0]   depth_w,
  input logic               empty_w,
  input logic               ack_fire_w
);
  a_r4_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |-> preempt_o && sys_nmi_o && !sys_fault_o);

  a_r5_fault_passes: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i && !nmi_i |-> preempt_o && sys_fault_o);

  a_r6_gmask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_i |-> !win_valid_o);

  a_r7_basepri_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o && (bp_w != '0) |-> win_prio_o < bp_w);

  a_r11_active_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> !act_o[win_idx_o]);

  a_r9_ack_moves_line: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire_w && !set_pend_i[win_idx_o] |=>
      act_o[$past(win_idx_o)] && !pend_o[$past(win_idx_o)]);

  a_r9_ack_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire_w |=> active_prio_o == $past(win_prio_o));

  a_r9_active_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_o) == int'(depth_w));

  a_r10_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_i && !empty_w |=> depth_w == $past(depth_w) - 1'b1);

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth_w) <= STACK_DEPTH);
endmodule

bind irq_prio_arb irq_arb_checker #(
  .N_LINES(N_LINES), .STACK_DEPTH(STACK_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .fault_i(fault_i),
  .gmask_i(gmask_i), .eoi_i(eoi_i), .set_pend_i(set_pend_i),
  .win_valid_o(win_valid_o), .win_idx_o(win_idx_o), .win_prio_o(win_prio_o),
  .preempt_o(preempt_o), .sys_nmi_o(sys_nmi_o), .sys_fault_o(sys_fault_o),
  .pend_o(pend_o), .act_o(act_o), .active_prio_o(active_prio_o),
  .bp_w(bp_w), .depth_w(depth_w), .empty_w(empty_w), .ack_fire_w(ack_fire_w)
);

// File: tb/irq_prio_arb_bench.sv
module irq_prio_arb_bench;
  localparam int N  = 16;
  localparam int IB = 4;
  localparam int SD = 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   req_b = '0, en_b = '0, setp_b = '0, clrp_b = '0;
  logic [7:0]     prio_b [N];
  logic [N*8-1:0] prio_flat;
  logic [2:0]     grp_b = '0;
  logic           gmask_b = 1'b0, nmi_b = 1'b0, fault_b = 1'b0;
  logic           ack_b = 1'b0, eoi_b = 1'b0;
  logic [7:0]     bpri_b = '0;

  logic          win_valid, preempt, s_nmi, s_fault;
  logic [IW-1:0] win_idx;
  logic [7:0]    win_prio, act_prio;
  logic [N-1:0]  pend, act;

  always_comb for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = prio_b[i];

  irq_prio_arb #(.N_LINES(N), .IMPL_BITS(IB), .STACK_DEPTH(SD)) u_irq_prio_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_b), .en_i(en_b), .prio_i(prio_flat),
    .group_i(grp_b), .gmask_i(gmask_b), .basepri_i(bpri_b), .nmi_i(nmi_b),
    .fault_i(fault_b), .ack_i(ack_b), .eoi_i(eoi_b), .set_pend_i(setp_b),
    .clr_pend_i(clrp_b), .win_valid_o(win_valid), .win_idx_o(win_idx),
    .win_prio_o(win_prio), .preempt_o(preempt), .sys_nmi_o(s_nmi),
    .sys_fault_o(s_fault), .pend_o(pend), .act_o(act), .active_prio_o(act_prio)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference state
  logic [N-1:0] m_pend = '0, m_act = '0, m_req_prev = '0;
  int           m_sp = 0;
  int           m_sprio [SD];
  int           m_sidx  [SD];
  bit           e_fire;
  int           e_idx, e_prio;

  function automatic int kept(int p);
    return p & (8'hFF << (8 - IB)) & 8'hFF;
  endfunction

  function automatic int lvl(int p, int g);
    return kept(p) >> (g + 1);
  endfunction

  task automatic chk(string rq, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act_v, exp_v, $time);
    end
  endtask

  task automatic compare();
    int  bp, best, bidx, top;
    bit  v, cpre;
    bp = kept(bpri_b);
    v = 0; best = 255; bidx = 0;
    for (int i = 0; i < N; i++) begin
      int p;
      p = kept(prio_b[i]);
      if (m_pend[i] && en_b[i] && !m_act[i] && !gmask_b &&
          (bp == 0 || p < bp) && (!v || p < best)) begin
        v = 1; best = p; bidx = i;
      end
    end
    top  = (m_sp == 0) ? 255 : m_sprio[m_sp-1];
    cpre = v && (m_sp < SD) && (m_sp == 0 || lvl(best, grp_b) < lvl(top, grp_b));
    // R1 R2 R6 R7 R11 R13: winner selection
    chk("R1 win_valid", int'(win_valid), int'(v));
    if (v) begin
      chk("R1 win_idx", int'(win_idx), bidx);
      chk("R2 win_prio", int'(win_prio), best);
    end
    // R3 R4 R5 R12: preemption and system sources
    chk("R3 preempt", int'(preempt), int'(nmi_b || fault_b || cpre));
    chk("R4 sys_nmi", int'(s_nmi), int'(nmi_b));
    chk("R5 sys_fault", int'(s_fault), int'(fault_b && !nmi_b));
    chk("R8 pend", int'(pend), int'(m_pend));
    chk("R9 act", int'(act), int'(m_act));
    chk("R10 active_prio", int'(act_prio), top);
    e_fire = ack_b && !eoi_b && !nmi_b && !fault_b && cpre;
    e_idx = bidx; e_prio = best;
  endtask

  task automatic update();
    logic [N-1:0] np;
    for (int i = 0; i < N; i++) begin
      if (clrp_b[i])                   np[i] = 1'b0;
      else if (setp_b[i])              np[i] = 1'b1;
      else if (e_fire && e_idx == i)   np[i] = 1'b0;
      else if (req_b[i] && !m_req_prev[i]) np[i] = 1'b1;
      else                             np[i] = m_pend[i];
    end
    m_pend = np;
    m_req_prev = req_b;
    if (eoi_b && m_sp > 0) begin
      m_sp--;
      m_act[m_sidx[m_sp]] = 1'b0;
    end else if (e_fire) begin
      m_sprio[m_sp] = e_prio; m_sidx[m_sp] = e_idx; m_sp++;
      m_act[e_idx] = 1'b1;
    end
  endtask

  task automatic step();
    #2; compare();
    @(posedge clk); update();
    @(negedge clk);
  endtask

  task automatic quiet();
    setp_b = '0; clrp_b = '0; ack_b = 0; eoi_b = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) prio_b[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // Reset state (R8, R9, R10)
    #2; compare();
    rst_n = 1'b1;
    @(negedge clk);
    en_b = '1; grp_b = 3'd3;

    // R9 R12: nest more urgent lines until the stack is full
    for (int k = 0; k <= SD; k++) begin
      prio_b[k] = 8'((15 - 2*k) << 4);
      setp_b = N'(1) << k; step(); quiet();
      ack_b = 1; step(); quiet();   // the last one is refused (R12)
    end
    // R10: retire all handlers, plus one extra eoi with an empty stack
    for (int k = 0; k <= SD; k++) begin eoi_b = 1; step(); quiet(); end
    clrp_b = '1; step(); quiet();

    // R2: low bits are ignored, equal kept priority goes to the lower index
    prio_b[3] = 8'h57; prio_b[7] = 8'h52;
    setp_b = (N'(1) << 3) | (N'(1) << 7); step(); quiet(); step();
    en_b[3] = 1'b0; step();           // R13: disabled line cannot win
    en_b[3] = 1'b1;
    bpri_b = 8'h5F; step();           // R7: kept 0x50 blocks 0x50
    bpri_b = 8'h60; step();           // R7: 0x50 passes
    bpri_b = 8'h00;
    gmask_b = 1; step();              // R6
    nmi_b = 1; step();                // R4 with global mask
    nmi_b = 0; fault_b = 1; step();   // R5
    fault_b = 0; gmask_b = 0;
    ack_b = 1; eoi_b = 1; step(); quiet(); // eoi wins, ack ignored
    ack_b = 1; step(); quiet();        // R9: line 3 accepted
    setp_b = N'(1) << 3; step(); quiet(); step(); // R11: active line pending
    eoi_b = 1; step(); quiet();
    clrp_b = '1; step(); quiet();

    // Random phase
    for (int s = 0; s < 4000; s++) begin
      req_b ^= N'($urandom & $urandom & $urandom);
      if ($urandom % 16 == 0) en_b = ~N'($urandom & $urandom & $urandom);
      prio_b[$urandom % N] = 8'($urandom);
      if ($urandom % 50 == 0) grp_b = 3'($urandom);
      gmask_b = ($urandom % 40 == 0);
      bpri_b  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      nmi_b   = ($urandom % 50 == 0);
      fault_b = ($urandom % 40 == 0);
      ack_b   = ($urandom % 3 == 0);
      eoi_b   = ($urandom % 6 == 0);
      setp_b  = N'($urandom & $urandom & $urandom & $urandom);
      clrp_b  = N'($urandom & $urandom & $urandom & $urandom);
      step();
    end
    summary();
  end
endmodule